// File: doc/BRIEF.md
# Character-to-Bit Serializer

This block converts a stream of 10-bit line characters into a single serial bit stream running ten times faster than the character rate. All logic runs on the bit clock. An internal phase counter divides that clock by ten and opens a one-cycle acceptance window that stands in for the character-rate reference edge. In that window the parallel word is captured into an input holding register. One character period later the word moves into a shift register, which sends it out least significant bit first.

The characters are assumed to be line-coded already. Each character is passed bit for bit with no change, and successive characters follow each other with no gap. The delay from capture to the first serial bit is fixed, so a receiver that knows the capture point can rebuild every word from the stream.

The input is a valid/ready stream with a fixed back-pressure pattern. `in_ready` is high for exactly one cycle in every ten, and a word transfers only in a cycle where `in_valid` and `in_ready` are both high. A source that wants every slot filled must hold its word until that cycle. If `in_valid` is low during the window, the slot still goes out on the line, filled with a fixed idle character.

Top module: `char_serializer`

## Requirements
- R1: While `rst_n` is low at a rising edge, `ser_out` and `in_ready` are 0 after that edge. A reset that arrives mid-stream discards every character not yet fully sent.
- R2: Number the rising edges with `rst_n` high after a reset from 1. `in_ready` is high exactly between edge 10k+9 and edge 10k+10 for k = 0, 1, 2, ..., and low at every other time.
- R3: A word is captured at the rising edge where `in_valid` and `in_ready` are both high. The value of `in_data` at any other edge has no effect on `ser_out`.
- R4: If `in_valid` is low at an edge where `in_ready` is high, the character sent for that slot is the idle character 10'b10_1000_0011 (parameter default).
- R5: Bits go out in the order bit 0 first and bit 9 last, one bit per bit clock.
- R6: Bit 0 of a character captured at edge n is driven on `ser_out` after edge n+11, and bit i after edge n+11+i.
- R7: Characters follow each other with no gap: bit 9 of one character is followed on the next edge by bit 0 of the next.
- R8: No coding is applied. Every 10-bit value, including all zeros, all ones and single-bit patterns, comes out unchanged.
- R9: After reset is released, `ser_out` stays 0 through edge 20, until the first captured character starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source has a character on `in_data` |
| in_ready | output | 1 | Acceptance window, one cycle in ten |
| in_data | input | 10 | Character, bit 0 sent first |
| ser_out | output | 1 | Serial bit stream |

## Verification
The hardest situation to reach is a reset that lands while characters are still in flight. At that moment one word sits in the holding register and another is half shifted out, and both must vanish without a stray bit. The stimulus pulses reset at an arbitrary phase in the middle of a random stream. It then checks that the line stays low until the first new character's bit 0 arrives at edge 21. The bench also changes `in_data` on every cycle and drops `in_valid` at random. This shows that only the window cycle matters and that empty slots carry the idle character.

// File: rtl/char_ser_pkg.sv
package char_ser_pkg;
  localparam int unsigned CHAR_W_DEF = 10;
  localparam logic [9:0]  IDLE_DEF   = 10'b10_1000_0011;
endpackage

// File: rtl/char_ser_phase.sv
module char_ser_phase #(
  parameter int unsigned RATIO = 10,
  localparam int unsigned CW = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic last
);
  localparam logic [CW-1:0] TOP = CW'(RATIO - 1);
  logic [CW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          phase_q <= '0;
    else if (phase_q == TOP) phase_q <= '0;
    else                 phase_q <= phase_q + 1'b1;
  end

  assign last = rst_n && (phase_q == TOP);
endmodule

// File: rtl/char_ser_latch.sv
module char_ser_latch #(
  parameter int unsigned W = 10,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         have,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (take) q <= have ? d : IDLE;
  end
endmodule

// File: rtl/char_ser_shift.sv
module char_ser_shift #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic         sout
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q <= '0;
      sout <= 1'b0;
    end else begin
      sout <= sr_q[0];
      if (load) sr_q <= d;
      else      sr_q <= {1'b0, sr_q[W-1:1]};
    end
  end
endmodule

// File: rtl/char_serializer.sv
module char_serializer
  import char_ser_pkg::*;
#(
  parameter int unsigned W = CHAR_W_DEF,
  parameter logic [W-1:0] IDLE = IDLE_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         ser_out
);
  logic         win;
  logic [W-1:0] lat_q;

  // one window per W bit clocks: character rate = bit rate / W
  char_ser_phase #(.RATIO(W)) u_phase (
    .clk(clk), .rst_n(rst_n), .last(win)
  );

  assign in_ready = win;

  char_ser_latch #(.W(W), .IDLE(IDLE)) u_latch (
    .clk(clk), .rst_n(rst_n), .take(win), .have(in_valid),
    .d(in_data), .q(lat_q)
  );

  // shifter reloads from the latch on the same window edge that refills it
  char_ser_shift #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(win), .d(lat_q), .sout(ser_out)
  );
endmodule

// File: rtl/char_serializer_chk.sv
module char_serializer_chk #(
  parameter int unsigned W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_ready,
  input logic         ser_out,
  input logic [W-1:0] lat_q
);
  logic [7:0] gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n || in_ready) gap_q <= '0;
    else if (gap_q != 8'hFF) gap_q <= gap_q + 1'b1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!ser_out && !in_ready)); // R1

  AST_WINDOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (gap_q == 8'(W - 1))); // R2

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(lat_q)); // R3

  AST_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_ready, 2) && $past(rst_n, 1)) |-> (ser_out == $past(lat_q[0], 2))); // R6
endmodule

bind char_serializer char_serializer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .ser_out(ser_out), .lat_q(lat_q)
);

// File: tb/char_serializer_tb.sv
module char_serializer_tb;
  localparam int W = 10;
  localparam logic [W-1:0] IDLE_TB = 10'b10_1000_0011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ready, ser_out;

  int checks = 0, failures = 0;
  int edge_n = 0, rst_edges = 0;
  logic exp_bits [64];
  logic done = 1'b0;

  always #4 clk = ~clk;

  char_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .ser_out(ser_out)
  );

  always @(posedge clk) begin
    if (!rst_n) begin edge_n <= 0; rst_edges <= rst_edges + 1; end
    else begin edge_n <= edge_n + 1; rst_edges <= 0; end
  end

  function automatic logic ready_expected(int e); // R2
    return (e % 10) == 9;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s edge=%0d actual=%b expected=%b", req, edge_n, act, exp);
    end
  endtask

  // monitor: sample at the falling edge
  initial begin
    for (int i = 0; i < 64; i++) exp_bits[i] = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        if (rst_edges >= 1) begin
          chk("R1 ser_out", ser_out, 1'b0);
          chk("R1 in_ready", in_ready, 1'b0);
        end
        for (int i = 0; i < 64; i++) exp_bits[i] = 1'b0;
      end else if (edge_n >= 1) begin
        // R5 R6 R7 R8 R9: bit expected after edge edge_n
        chk((edge_n <= 20) ? "R9 line" : "R6 serial bit", ser_out, exp_bits[edge_n % 64]);
        exp_bits[edge_n % 64] = 1'b0;
        chk("R2 window", in_ready, ready_expected(edge_n));
        if (in_ready) begin
          logic [W-1:0] w;
          w = in_valid ? in_data : IDLE_TB; // R3 R4
          for (int i = 0; i < W; i++)
            exp_bits[(edge_n + 1 + 11 + i) % 64] = w[i];
        end
      end
    end
  end

  task automatic drive(input logic v, input logic [W-1:0] d);
    @(posedge clk); #1;
    in_valid = v; in_data = d;
  endtask

  task automatic send(input logic [W-1:0] w); // waits for the window
    in_valid = 1'b1; in_data = w;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_data = $urandom;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9: idle slots right after reset, data toggling while not accepted (R3)
    repeat (25) drive(1'b0, W'($urandom));
    // R8 directed corner characters, back to back (R7)
    send(10'h000); send(10'h3FF); send(10'h001); send(10'h200);
    send(10'h0F8); send(10'h307); send(10'h155); send(10'h2AA);
    // R4: empty slots carry the idle character
    repeat (30) drive(1'b0, W'($urandom));
    // R3 R5 R6: random data every cycle, valid mostly high
    repeat (800) drive(($urandom % 4) != 0, W'($urandom));
    // R1: reset at an arbitrary phase mid-stream
    repeat (7) drive(1'b1, W'($urandom));
    #1 rst_n = 1'b0;
    repeat (3) drive(1'b1, W'($urandom));
    #1 rst_n = 1'b1;
    repeat (30) drive(1'b0, W'($urandom)); // R9 after mid-stream reset
    repeat (800) drive(($urandom % 2) != 0, W'($urandom));
    repeat (25) drive(1'b0, W'($urandom));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule